// File: doc/BRIEF.md
# Register Window Translator

This block sits on the register-direct address path of a CPU core. Every direct access carries an 8-bit address into the lower register file. Normally that address passes to memory with a zero high byte. A window selection register can make the top of the direct space stand in for a segment of higher memory. The window can be 32, 64 or 128 bytes, and it is always aligned to the top of the direct space. The selection code carries both the window size and the segment index. The segment base is the index shifted left by the window size, plus a fixed base of 1800H.

Accesses arrive on a request channel that uses valid/ready. Accesses that need memory go out on a second valid/ready channel to the memory arrays. The translator takes one of two paths:

- **Forward to memory.** The access is passed through combinationally. The request completes in the cycle both channels are valid and ready. While `mem_ready` is low, `req_ready` is low too, and the requester must hold its request stable.
- **Complete at once.** `req_ready` is high with no memory request. This covers two cases: accesses to the selection register itself, and accesses through a window that land on the protected range 1FE0H–1FFFH. A protected-range read returns FFH and a protected-range write is dropped.

Top module: `regwin_xlate`

## Requirements
- R1: After reset the selection register reads 00H and windowing is off.
- R2: The selection register sits at direct address 14H. A write handshake there loads `req_wdata`, and a read there returns its value on `req_rdata`. Neither access is ever forwarded to memory.
- R3: A new selection value governs the access that follows its write, starting in the very next cycle.
- R4: With a selection value below 10H, every direct address goes to memory as `{8'h00, addr}` and `win_hit` is low.
- R5: Codes 40H–7FH select a 32-byte window over direct 00E0H–00FFH. The mapping is `mem_addr = 1800H + sel[5:0]*32 + addr[4:0]`.
- R6: Codes 20H–3FH select a 64-byte window over 00C0H–00FFH. The mapping is `mem_addr = 1800H + sel[4:0]*64 + addr[5:0]`.
- R7: Codes 10H–1FH select a 128-byte window over 0080H–00FFH. The mapping is `mem_addr = 1800H + sel[3:0]*128 + addr[6:0]`.
- R8: Direct addresses below the active window's start are never translated. This includes the CPU special registers at 00H–17H and the stack pointer at 18H–19H.
- R9: A windowed access whose translated address falls in 1FE0H–1FFFH is blocked. For such an access:
  - `win_blocked` and `rd_override` are high.
  - `mem_valid` stays low.
  - `req_ready` is high.
  - A read returns FFH and a write has no effect.
- R10: A forwarded access raises `mem_valid` together with `req_valid`, and `req_ready` follows `mem_ready`. A read returns `mem_rdata` with `rd_override` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Direct access request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Direct register address |
| req_wdata | input | 8 | Write data |
| req_rdata | output | 8 | Read data, valid at handshake |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts access |
| mem_write | output | 1 | Memory write enable |
| mem_addr | output | 16 | Translated memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| win_hit | output | 1 | Current address is inside the active window |
| win_blocked | output | 1 | Windowed access reaches the protected range |
| rd_override | output | 1 | Read data comes from the translator, not memory |

## Verification
The bench builds the block with its default parameters. These are a 1800H segment base, the protected range at 1FE0H–1FFFH, and the selection register at 14H. With these values every code class can reach the protected range:

- Code 3FH splits its 64-byte window into a usable half and a blocked half.
- Code 7FH makes every access through its 32-byte window blocked.

The bench also covers window start boundaries, addresses one below each boundary, and the stack pointer and special-register addresses under a 128-byte window. It holds `mem_ready` low to show the stall, and it writes the selection register immediately before a dependent access.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int DIR_W  = 8;
  localparam int DATA_W = 8;
  localparam int N_SIZES = 3;

  typedef enum logic [1:0] {
    ROUTE_MEM,
    ROUTE_SEL,
    ROUTE_BLOCK
  } route_e;
endpackage

// File: rtl/regwin_selreg.sv
module regwin_selreg
  import regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DIR_W-1:0]  din,
  output logic [DIR_W-1:0]  sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (load) sel_q <= din;
  end

  // R2: load captures the write data; R3: otherwise the value holds
  p_sel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sel_q == $past(din));
  p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sel_q));
endmodule

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SEG_BASE = 16'h1800,
  parameter logic [ADDR_W-1:0] PROT_LO  = 16'h1FE0,
  parameter logic [ADDR_W-1:0] PROT_HI  = 16'h1FFF
) (
  input  logic [DIR_W-1:0]  sel,
  input  logic [DIR_W-1:0]  addr,
  output logic              hit,
  output logic              blocked,
  output logic [ADDR_W-1:0] xaddr
);
  logic [N_SIZES-1:0] cls;
  logic [N_SIZES-1:0] inr;
  logic [ADDR_W-1:0]  xl [N_SIZES];

  // k = 0: 128-byte window, k = 1: 64-byte, k = 2: 32-byte
  for (genvar k = 0; k < N_SIZES; k++) begin : g_size
    localparam int OB = 7 - k;   // offset bits inside the window
    localparam int SB = 4 + k;   // segment index bits in the code
    assign cls[k] = (sel[DIR_W-1:SB] == {{(DIR_W-SB-1){1'b0}}, 1'b1});
    assign inr[k] = &addr[DIR_W-1:OB];
    assign xl[k]  = SEG_BASE
                  + ADDR_W'({sel[SB-1:0], {OB{1'b0}}})
                  + ADDR_W'(addr[OB-1:0]);
  end

  always_comb begin
    xaddr = {{(ADDR_W-DIR_W){1'b0}}, addr};
    hit   = 1'b0;
    for (int k = 0; k < N_SIZES; k++) begin
      if (cls[k] && inr[k]) begin
        xaddr = xl[k];
        hit   = 1'b1;
      end
    end
    blocked = hit && (xaddr >= PROT_LO) && (xaddr <= PROT_HI);
  end
endmodule

// File: rtl/regwin_xlate.sv
module regwin_xlate
  import regwin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SEG_BASE = 16'h1800,
  parameter logic [ADDR_W-1:0] PROT_LO  = 16'h1FE0,
  parameter logic [ADDR_W-1:0] PROT_HI  = 16'h1FFF,
  parameter logic [DIR_W-1:0]  SEL_ADDR = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DIR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] req_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              win_hit,
  output logic              win_blocked,
  output logic              rd_override
);
  logic [DIR_W-1:0]  sel_q;
  logic              dec_hit, dec_blk;
  logic [ADDR_W-1:0] dec_addr;
  route_e            route;
  logic              sel_load;

  regwin_decode #(
    .ADDR_W(ADDR_W), .SEG_BASE(SEG_BASE), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
  ) u_dec (
    .sel(sel_q), .addr(req_addr),
    .hit(dec_hit), .blocked(dec_blk), .xaddr(dec_addr)
  );

  always_comb begin
    if (req_addr == SEL_ADDR) route = ROUTE_SEL;
    else if (dec_blk)         route = ROUTE_BLOCK;
    else                      route = ROUTE_MEM;
  end

  assign mem_valid   = req_valid && (route == ROUTE_MEM);
  assign mem_write   = req_write;
  assign mem_addr    = dec_addr;
  assign mem_wdata   = req_wdata;
  assign req_ready   = (route == ROUTE_MEM) ? mem_ready : 1'b1;
  assign rd_override = (route != ROUTE_MEM);
  assign win_hit     = dec_hit;
  assign win_blocked = dec_blk;

  always_comb begin
    unique case (route)
      ROUTE_SEL:   req_rdata = sel_q;
      ROUTE_BLOCK: req_rdata = '1;
      default:     req_rdata = mem_rdata;
    endcase
  end

  assign sel_load = req_valid && req_write && (route == ROUTE_SEL);

  regwin_selreg u_sel (
    .clk(clk), .rst_n(rst_n), .load(sel_load), .din(req_wdata), .sel_q(sel_q)
  );

  // R9: a blocked access never reaches memory and completes at once
  p_blk_nomem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_blocked) |-> (!mem_valid && req_ready));
  // R10: forwarded access waits for the memory side
  p_ready_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (req_ready == mem_ready));
  // R4: codes below 10H never open a window
  p_off_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q < 8'h10) |-> !win_hit);
  // R8: special registers and stack pointer go out untranslated
  p_low_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && req_addr < 8'h1A) |-> mem_addr == {{(ADDR_W-DIR_W){1'b0}}, req_addr});
  // R2: the selection register is never forwarded
  p_sel_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr == SEL_ADDR) |-> !mem_valid);
endmodule

// File: tb/regwin_xlate_tb_top.sv
`timescale 1ns/1ps
module regwin_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = 8'h00, req_wdata = 8'h00;
  logic        req_ready;
  logic [7:0]  req_rdata;
  logic        mem_valid, mem_write, mem_ready;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        win_hit, win_blocked, rd_override;
  logic        mem_rdy_drv = 1'b1;

  int vectors = 0, errors = 0;
  logic [7:0] sel_model = 8'h00;

  always #4 clk = ~clk;

  assign mem_ready = mem_rdy_drv;
  assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'h5A;

  regwin_xlate dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .win_hit(win_hit), .win_blocked(win_blocked), .rd_override(rd_override)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // expected translation computed from the size/segment rules
  function automatic int exp_map(input int s, input int a, output bit windowed);
    windowed = 1'b1;
    if (s >= 'h40 && a >= 'hE0)      return 'h1800 + (s - 'h40) * 32  + (a - 'hE0);
    else if (s >= 'h20 && s < 'h40 && a >= 'hC0) return 'h1800 + (s - 'h20) * 64  + (a - 'hC0);
    else if (s >= 'h10 && s < 'h20 && a >= 'h80) return 'h1800 + (s - 'h10) * 128 + (a - 'h80);
    windowed = 1'b0;
    return a;
  endfunction

  task automatic set_sel(input string tag, input logic [7:0] v);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h14; req_wdata = v;
    @(negedge clk);
    chk(tag, "sel write ready", int'(req_ready), 1);
    chk(tag, "sel write no mem", int'(mem_valid), 0);
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
    sel_model = v;
  endtask

  task automatic read_sel(input string tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h14;
    @(negedge clk);
    chk(tag, "sel readback", int'(req_rdata), int'(sel_model));
    chk(tag, "sel read no mem", int'(mem_valid), 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // one access; all expectations derived from sel_model
  task automatic probe(input string tag, input logic wr, input logic [7:0] a);
    bit win; int xa; bit blk;
    xa  = exp_map(int'(sel_model), int'(a), win);
    blk = win && xa >= 'h1FE0;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = a ^ 8'hC3;
    @(negedge clk);
    chk(tag, "win_hit", int'(win_hit), int'(win));
    chk(tag, "win_blocked", int'(win_blocked), int'(blk));
    chk(tag, "mem_valid", int'(mem_valid), int'(!blk));
    chk(tag, "req_ready", int'(req_ready), 1);
    if (!blk) begin
      chk(tag, "mem_addr", int'(mem_addr), xa);
      chk(tag, "mem_write", int'(mem_write), int'(wr));
      if (!wr) chk(tag, "rdata", int'(req_rdata), int'((xa & 'hFF) ^ (xa >> 8) ^ 'h5A));
    end else if (!wr) begin
      chk(tag, "blocked rdata", int'(req_rdata), 'hFF);
      chk(tag, "rd_override", int'(rd_override), 1);
    end
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic t_reset;
    read_sel("R1");
    probe("R1", 1'b0, 8'hE5);
    probe("R4", 1'b0, 8'hFF);
  endtask

  task automatic t_off;
    set_sel("R2", 8'h0F);
    read_sel("R2");
    probe("R4", 1'b0, 8'hFF);
    probe("R4", 1'b1, 8'h80);
  endtask

  task automatic t_32;
    set_sel("R5", 8'h70);
    probe("R5", 1'b0, 8'hE3);
    probe("R5", 1'b1, 8'hFF);
    probe("R8", 1'b0, 8'hDF);
  endtask

  task automatic t_64;
    set_sel("R6", 8'h3C);
    probe("R6", 1'b0, 8'hC1);
    probe("R8", 1'b0, 8'hBF);
    set_sel("R6", 8'h3F);
    probe("R6", 1'b0, 8'hC5);
    probe("R9", 1'b0, 8'hE0);
    probe("R9", 1'b1, 8'hFF);
  endtask

  task automatic t_128;
    set_sel("R7", 8'h1C);
    probe("R7", 1'b0, 8'h80);
    probe("R7", 1'b0, 8'hFF);
    probe("R8", 1'b0, 8'h7F);
    probe("R8", 1'b0, 8'h19);
    probe("R8", 1'b0, 8'h00);
  endtask

  task automatic t_next;
    set_sel("R3", 8'h1C);
    probe("R3", 1'b0, 8'hE0);
    set_sel("R3", 8'h7F);
    probe("R3", 1'b0, 8'hE0);
    probe("R9", 1'b0, 8'hF7);
  endtask

  task automatic t_stall;
    set_sel("R10", 8'h00);
    @(posedge clk); #1;
    mem_rdy_drv = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h42;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R10", "stall mem_valid", int'(mem_valid), 1);
      chk("R10", "stall req_ready", int'(req_ready), 0);
    end
    #1 mem_rdy_drv = 1'b1;
    @(negedge clk);
    chk("R10", "release ready", int'(req_ready), 1);
    chk("R10", "rdata", int'(req_rdata), 'h42 ^ 'h5A);
    chk("R10", "rd_override", int'(rd_override), 0);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_off();
    t_32();
    t_64();
    t_128();
    t_next();
    t_stall();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule